// File: doc/BRIEF.md
# Piecewise-Linear Sigmoid Unit

This block turns a signed fixed-point value into an approximation of the logistic sigmoid. It is meant to sit behind a neuron's weighted-sum accumulator, where it turns each net input into an activation between zero and one. There is no table memory. The magnitude of the input picks one of four straight-line pieces, and each piece has a power-of-two slope, so the multiply is a right shift. A negative input takes the mirror image about one half: the result is one minus the value for its magnitude.

The work is split over two registered stages. The first stage takes the magnitude, picks the piece, and forms both the shifted product and the intercept. The second stage adds the two, applies the mirror for negative inputs, and clamps the result to the range from zero to one. A new input may arrive on every cycle, and each result appears exactly two cycles after its input.

Top module: `sigmoid_pwl`

## Requirements
- R1: While reset is held and on the first cycle after reset, out_valid is low and out_act is zero.
- R2: Each cycle with in_valid high produces exactly one cycle with out_valid high, two clock cycles later. A cycle with in_valid low produces none, so idle gaps and back-to-back inputs keep their spacing.
- R3: Values are two's complement, with FRAC_W fractional bits (ONE = 2^FRAC_W). For 0 <= |x| < 1, a non-negative input gives floor(|x|/4) + ONE/2 in LSBs.
- R4: For 1 <= |x| < 2.375, a non-negative input gives floor(|x|/8) + 5*ONE/8. The knee value 1.0 itself belongs to this piece.
- R5: For 2.375 <= |x| < 5, a non-negative input gives floor(|x|/32) + 27*ONE/32. The knee value 2.375 itself belongs to this piece.
- R6: For |x| >= 5, including the value 5.0 itself and the largest positive code, a non-negative input gives exactly ONE.
- R7: A negative input gives ONE minus the value that R3 to R6 give for its magnitude. The most negative code is treated as a magnitude of 2^(DATA_W-1) and so gives zero.
- R8: Every valid output lies between 0 and ONE inclusive.
- R9: In a cycle where out_valid is low, out_act keeps the value it had in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The input value is present this cycle |
| in_x | input | DATA_W | Signed fixed-point input with FRAC_W fractional bits |
| out_valid | output | 1 | The activation is present this cycle |
| out_act | output | DATA_W | Activation in the range 0 to ONE, same format as the input |

## Verification
The bench builds two copies of the block. The first uses DATA_W=12 and FRAC_W=6, which is small enough to sweep all 4096 input codes. That sweep covers every piece boundary from both sides, both signs, and the most negative and most positive codes, and idle cycles are mixed into the stream. The second copy uses the default DATA_W=32 and FRAC_W=16. It gets the knees and their neighbours, both ends of the range and zero as directed values, followed by pseudo-random inputs whose magnitudes are shifted so that every piece is reached.

// File: rtl/sigmoid_pwl_pkg.sv
package sigmoid_pwl_pkg;

  localparam int NUM_SEG  = 4;
  localparam int NUM_KNEE = NUM_SEG - 1;

  typedef logic [1:0] seg_t;

  // Lower bound of piece idx+1, as a magnitude in LSBs: 1.0, 2.375, 5.0
  function automatic logic [63:0] knee_at(input int idx, input int frac);
    logic [63:0] one;
    one = 64'd1 << frac;
    case (idx)
      0:       knee_at = one;
      1:       knee_at = (64'd19 * one) >> 3;
      default: knee_at = 64'd5 * one;
    endcase
  endfunction

  // Right shift that forms the slope of a piece; -1 marks the flat piece
  function automatic int slope_shift(input int seg);
    case (seg)
      0:       slope_shift = 2;
      1:       slope_shift = 3;
      2:       slope_shift = 5;
      default: slope_shift = -1;
    endcase
  endfunction

  // Intercept of a piece in LSBs: 0.5, 0.625, 0.84375, 1.0
  function automatic logic [63:0] icpt_at(input int seg, input int frac);
    logic [63:0] one;
    one = 64'd1 << frac;
    case (seg)
      0:       icpt_at = one >> 1;
      1:       icpt_at = (64'd5 * one) >> 3;
      2:       icpt_at = (64'd27 * one) >> 5;
      default: icpt_at = one;
    endcase
  endfunction

endpackage

// File: rtl/sigmoid_pwl_knees.sv
module sigmoid_pwl_knees
  import sigmoid_pwl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic [DATA_W-1:0]   mag,
  output logic [NUM_KNEE-1:0] knee_hit,
  output seg_t                seg
);

  for (genvar k = 0; k < NUM_KNEE; k++) begin : g_knee
    localparam logic [DATA_W-1:0] KNEE = DATA_W'(knee_at(k, FRAC_W));
    assign knee_hit[k] = (mag >= KNEE);
  end

  // Knees rise with k, so the passed ones form a thermometer code
  always_comb begin
    seg = seg_t'($countones(knee_hit));
  end

endmodule

// File: rtl/sigmoid_pwl_s1.sv
module sigmoid_pwl_s1
  import sigmoid_pwl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   in_x,
  output logic [NUM_KNEE-1:0] knee_hit,
  output logic                s1_valid,
  output logic                s1_neg,
  output seg_t                s1_seg,
  output logic [DATA_W-1:0]   s1_prod,
  output logic [DATA_W-1:0]   s1_icpt
);

  logic              neg_c;
  logic [DATA_W-1:0] mag_c;
  seg_t              seg_c;
  logic [DATA_W-1:0] cand_prod [NUM_SEG];
  logic [DATA_W-1:0] cand_icpt [NUM_SEG];

  assign neg_c = in_x[DATA_W-1];
  // The most negative code gives 2^(DATA_W-1) when read as unsigned
  assign mag_c = neg_c ? (~in_x + 1'b1) : in_x;

  sigmoid_pwl_knees #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_knees (
    .mag      (mag_c),
    .knee_hit (knee_hit),
    .seg      (seg_c)
  );

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam int SH = slope_shift(g);
    if (SH < 0) begin : g_flat
      assign cand_prod[g] = '0;
    end else begin : g_slope
      assign cand_prod[g] = mag_c >> SH;
    end
    assign cand_icpt[g] = DATA_W'(icpt_at(g, FRAC_W));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_neg   <= 1'b0;
      s1_seg   <= '0;
      s1_prod  <= '0;
      s1_icpt  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_neg  <= neg_c;
        s1_seg  <= seg_c;
        s1_prod <= cand_prod[seg_c];
        s1_icpt <= cand_icpt[seg_c];
      end
    end
  end

endmodule

// File: rtl/sigmoid_pwl_s2.sv
module sigmoid_pwl_s2
  import sigmoid_pwl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  logic              s1_neg,
  input  logic [DATA_W-1:0] s1_prod,
  input  logic [DATA_W-1:0] s1_icpt,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_act
);

  localparam int WIDE_W = DATA_W + 2;
  localparam logic signed [WIDE_W-1:0] ONE_W = WIDE_W'(64'd1 << FRAC_W);

  // Keeps a signed wide value inside the range 0 to ONE
  function automatic logic signed [WIDE_W-1:0] clamp01(input logic signed [WIDE_W-1:0] v);
    if (v < 0)          clamp01 = '0;
    else if (v > ONE_W) clamp01 = ONE_W;
    else                clamp01 = v;
  endfunction

  logic signed [WIDE_W-1:0] sum_c;
  logic signed [WIDE_W-1:0] mirror_c;
  logic signed [WIDE_W-1:0] res_c;

  assign sum_c    = $signed({2'b00, s1_prod}) + $signed({2'b00, s1_icpt});
  assign mirror_c = s1_neg ? (ONE_W - sum_c) : sum_c;
  assign res_c    = clamp01(mirror_c);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_act   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_act <= res_c[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/sigmoid_pwl.sv
module sigmoid_pwl
  import sigmoid_pwl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_x,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_act
);

  if (FRAC_W < 5 || DATA_W - FRAC_W < 4) begin : g_bad_cfg
    $error("sigmoid_pwl: needs FRAC_W >= 5 and DATA_W - FRAC_W >= 4");
  end

  logic [NUM_KNEE-1:0] knee_hit;
  logic                s1_valid;
  logic                s1_neg;
  seg_t                s1_seg;
  logic [DATA_W-1:0]   s1_prod;
  logic [DATA_W-1:0]   s1_icpt;

  sigmoid_pwl_s1 #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_s1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_x     (in_x),
    .knee_hit (knee_hit),
    .s1_valid (s1_valid),
    .s1_neg   (s1_neg),
    .s1_seg   (s1_seg),
    .s1_prod  (s1_prod),
    .s1_icpt  (s1_icpt)
  );

  sigmoid_pwl_s2 #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_s2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_neg    (s1_neg),
    .s1_prod   (s1_prod),
    .s1_icpt   (s1_icpt),
    .out_valid (out_valid),
    .out_act   (out_act)
  );

endmodule

// File: rtl/sigmoid_pwl_chk.sv
module sigmoid_pwl_chk
  import sigmoid_pwl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                out_valid,
  input logic [DATA_W-1:0]   out_act,
  input logic [NUM_KNEE-1:0] knee_hit,
  input logic                s1_valid,
  input logic                s1_neg,
  input seg_t                s1_seg
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(64'd1 << FRAC_W);

  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_valid && out_act == '0));

  a_r2_lat_on: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  a_r2_lat_off: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  // R5: piece selection relies on the knees being passed in order
  a_r5_knee_order: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((!knee_hit[2] || knee_hit[1]) && (!knee_hit[1] || knee_hit[0])));

  a_r6_flat_top: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_neg && s1_seg == 2'd3) |=> (out_act == ONE));

  a_r7_flat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_neg && s1_seg == 2'd3) |=> (out_act == '0));

  a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_act <= ONE));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_act));

endmodule

bind sigmoid_pwl sigmoid_pwl_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_act   (out_act),
  .knee_hit  (knee_hit),
  .s1_valid  (s1_valid),
  .s1_neg    (s1_neg),
  .s1_seg    (s1_seg)
);

// File: tb/sim_sigmoid_pwl.sv
`timescale 1ns/1ps
module sim_sigmoid_pwl;

  localparam int SW = 12, SF = 6;
  localparam int BW = 32, BF = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          s_iv = 1'b0, b_iv = 1'b0;
  logic [SW-1:0] s_x = '0;
  logic [BW-1:0] b_x = '0;
  logic          s_ov, b_ov;
  logic [SW-1:0] s_y;
  logic [BW-1:0] b_y;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  sigmoid_pwl #(.DATA_W(SW), .FRAC_W(SF)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(s_iv), .in_x(s_x),
    .out_valid(s_ov), .out_act(s_y));

  sigmoid_pwl #(.DATA_W(BW), .FRAC_W(BF)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(b_iv), .in_x(b_x),
    .out_valid(b_ov), .out_act(b_y));

  // Expected activation, written from the piece equations by integer division
  function automatic longint ref_act(input longint x, input int frac);
    longint one, mag, y;
    one = longint'(1) <<< frac;
    mag = (x < 0) ? -x : x;
    if (mag >= 5 * one)           y = one;
    else if (8 * mag >= 19 * one) y = (mag + 27 * one) / 32;
    else if (mag >= one)          y = (mag + 5 * one) / 8;
    else                          y = (mag + 2 * one) / 4;
    if (x < 0) y = one - y;
    return y;
  endfunction

  function automatic string req_of(input longint x, input int frac);
    longint one, mag;
    one = longint'(1) <<< frac;
    mag = (x < 0) ? -x : x;
    if (x < 0)                    return "R7";
    if (mag >= 5 * one)           return "R6";
    if (8 * mag >= 19 * one)      return "R5";
    if (mag >= one)               return "R4";
    return "R3";
  endfunction

  function automatic longint dir_val(input int i);
    case (i)
      0: return 0;             1: return 1;
      2: return -1;            3: return 'h10000;
      4: return 'hFFFF;        5: return 'h26000;
      6: return 'h25FFF;       7: return 'h50000;
      8: return 'h4FFFF;       9: return -'h50000;
      10: return -'h26000;     11: return 'h7FFFFFFF;
      12: return -'h80000000;  13: return -'h10000;
      14: return 'h8000;       default: return -'h8000;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expectation pipelines, index 1 is what the outputs show this cycle
  bit     sp_v [2], bp_v [2];
  longint sp_y [2], bp_y [2];
  string  sp_r [2], bp_r [2];
  longint s_last = 0, b_last = 0;

  task automatic monitor();
    longint sone, bone;
    sone = longint'(1) <<< SF;
    bone = longint'(1) <<< BF;
    check(s_ov == sp_v[1], "R2", "small out_valid", s_ov, sp_v[1]);
    check(b_ov == bp_v[1], "R2", "wide out_valid", b_ov, bp_v[1]);
    if (sp_v[1]) begin
      check(longint'(s_y) == sp_y[1], sp_r[1], "small activation", s_y, sp_y[1]);
      check(longint'(s_y) <= sone, "R8", "small range", s_y, sone);
      s_last = longint'(s_y);
    end else begin
      check(longint'(s_y) == s_last, "R9", "small hold", s_y, s_last);
    end
    if (bp_v[1]) begin
      check(longint'(b_y) == bp_y[1], bp_r[1], "wide activation", b_y, bp_y[1]);
      check(longint'(b_y) <= bone, "R8", "wide range", b_y, bone);
      b_last = longint'(b_y);
    end else begin
      check(longint'(b_y) == b_last, "R9", "wide hold", b_y, b_last);
    end
    sp_v[1] = sp_v[0]; sp_y[1] = sp_y[0]; sp_r[1] = sp_r[0];
    bp_v[1] = bp_v[0]; bp_y[1] = bp_y[0]; bp_r[1] = bp_r[0];
  endtask

  initial begin
    logic [31:0] lfsr;
    int s_idx, b_idx, cyc;
    lfsr = 32'h1234_5678;
    s_idx = 0; b_idx = 0; cyc = 0;
    for (int k = 0; k < 2; k++) begin
      sp_v[k] = 1'b0; bp_v[k] = 1'b0; sp_y[k] = 0; bp_y[k] = 0;
      sp_r[k] = ""; bp_r[k] = "";
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!s_ov && s_y == '0, "R1", "small idle in reset", s_y, 0);
    check(!b_ov && b_y == '0, "R1", "wide idle in reset", b_y, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!s_ov && s_y == '0, "R1", "small idle after reset", s_y, 0);
    check(!b_ov && b_y == '0, "R1", "wide idle after reset", b_y, 0);

    while (s_idx < (1 << SW)) begin
      @(negedge clk);
      monitor();
      if (cyc % 7 == 6) begin
        s_iv = 1'b0; b_iv = 1'b0;
        s_x = '1; b_x = '1;
        sp_v[0] = 1'b0; bp_v[0] = 1'b0;
      end else begin
        longint sv, bv;
        sv = longint'(s_idx) - (longint'(1) <<< (SW - 1));
        if (b_idx < 16) bv = dir_val(b_idx);
        else bv = longint'($signed(lfsr) >>> (8 + int'(lfsr[3:0])));
        lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
        s_iv = 1'b1; b_iv = 1'b1;
        s_x = SW'(sv); b_x = BW'(bv);
        sp_v[0] = 1'b1; sp_y[0] = ref_act(sv, SF); sp_r[0] = req_of(sv, SF);
        bp_v[0] = 1'b1; bp_y[0] = ref_act(bv, BF); bp_r[0] = req_of(bv, BF);
        s_idx++; b_idx++;
      end
      cyc++;
    end
    repeat (3) begin
      @(negedge clk);
      monitor();
      s_iv = 1'b0; b_iv = 1'b0;
      s_x = '0; b_x = '0;
      sp_v[0] = 1'b0; bp_v[0] = 1'b0;
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule